// File: doc/BRIEF.md
# Signed-Count Bidirectional Shifter with Status Flags

This block shifts a 32-bit operand by a signed amount and reports status flags for the result. The amount comes from a 16-bit count operand. Only its low six bits are used, and they are read as a two's-complement number from -32 to +31. A positive amount shifts left and fills with zeros. A negative amount shifts right by its magnitude. The fill on a right shift depends on the mode select: arithmetic mode copies the sign bit, logical mode inserts zeros. Because only six bits are kept, a large count wraps around: 40 becomes a right shift by 24, and 255 becomes a right shift by 1.

The shift and the flag logic are combinational. The result and the flags are captured in output registers on the rising edge where the input strobe is high, and the output strobe then pulses for one cycle. The flags are: zero, negative (bit 31 of the result), carry, and two overflow bits. For this operation the carry and both overflow bits always read as zero. They are cleared even when a left shift pushes set bits out of the top.

Top module: `count_shift_unit`

## Requirements
- R1: Only count bits [5:0] are used, read as a signed value in -32..+31; bits [15:6] have no effect (255 acts as -1, 63 as -1, 40 as -24, 32 as -32).
- R2: A count from +1 to +31 shifts the operand left by that amount, fills with zeros and discards bits that leave bit 31 (0x80000001 by 1 gives 0x00000002, by 31 gives 0x80000000).
- R3: With arithModeIn = 1, a negative count shifts right by its magnitude, filling with bit 31 of the operand; -32 yields all copies of the sign bit (0x80000001 by -24 gives 0xFFFFFF80).
- R4: With arithModeIn = 0, a negative count shifts right filling with zeros; -32 yields zero (0x80000001 by -1 gives 0x40000000, by -31 gives 0x00000001).
- R5: A count whose low six bits are zero passes the operand through unchanged.
- R6: flagZero is 1 exactly when the registered 32-bit result is zero.
- R7: flagNeg equals bit 31 of the registered result.
- R8: flagCarry, flagOvf0 and flagOvf1 are always 0, even when a left shift drops set bits.
- R9: When inValid is high at a rising edge, the result and flags of that edge's inputs appear after that edge, and outValid is high for exactly that following cycle; otherwise outValid is low.
- R10: While inValid is low, the result and flag outputs hold their last values whatever the data inputs do.
- R11: A synchronous active-high rst clears the result, all flags and outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input strobe; capture this cycle's shift |
| operandIn | input | 32 | Value to be shifted |
| countIn | input | 16 | Shift count; low six bits used as a signed amount |
| arithModeIn | input | 1 | 1 = arithmetic (sign fill), 0 = logical (zero fill) |
| outValid | output | 1 | One-cycle pulse marking a fresh result |
| resultOut | output | 32 | Registered shift result |
| flagZero | output | 1 | Result is all zeros |
| flagNeg | output | 1 | Bit 31 of the result |
| flagCarry | output | 1 | Carry flag, always 0 |
| flagOvf0 | output | 1 | First overflow flag, always 0 |
| flagOvf1 | output | 1 | Second overflow flag, always 0 |

## Verification
Directed cases use the operand 0x80000001. Its set bits at both ends show a lost top bit on left shifts and show the fill on right shifts. It is shifted by +1, +31, -1, -24, -31 and -32 in both modes, which separates sign fill from zero fill and tests the full-width shift. Counts of 32, 40, 63 and 255 are also applied, some with upper count bits set, to show that the count wraps into the opposite direction and that bits above bit 5 are ignored. Zero operands and zero counts exercise the zero flag and the pass-through. Random operands, counts and modes then cover every shift amount against a reference model. Between shifts, the data inputs change with the strobe low, and one reset is issued mid-run, to show that the outputs hold and that reset clears them.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic {
    FILL_ZERO = 1'b0,
    FILL_SIGN = 1'b1
  } fill_mode_e;

  typedef struct packed {
    logic load;
    logic clear;
  } ctrl_strobe_t;

  typedef struct packed {
    logic zero;
    logic neg;
    logic carry;
    logic ovf0;
    logic ovf1;
  } flag_set_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output ctrl_strobe_t strobes,
  output logic         outValid
);

  always_comb begin
    strobes.clear = rst;
    strobes.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  ctrl_strobe_t      strobes,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [SEL_W-1:0]  stepIn,
  input  fill_mode_e        fillMode,
  output logic [DATA_W-1:0] resultOut,
  output flag_set_t         flagsOut
);

  localparam int LEFT_STAGES = SEL_W - 1;

  logic              goLeft;
  logic [SEL_W-2:0]  leftAmt;
  logic [SEL_W-1:0]  rightMag;
  logic              fillBit;
  logic [DATA_W-1:0] shiftOut;
  flag_set_t         flagsNext;

  logic [DATA_W-1:0] leftStage  [LEFT_STAGES+1];
  logic [DATA_W-1:0] rightStage [SEL_W+1];

  // Sign of the short count picks the direction; negation gives the magnitude.
  assign goLeft   = ~stepIn[SEL_W-1];
  assign leftAmt  = stepIn[SEL_W-2:0];
  assign rightMag = SEL_W'(-stepIn);
  assign fillBit  = (fillMode == FILL_SIGN) & operandIn[DATA_W-1];

  assign leftStage[0]  = operandIn;
  assign rightStage[0] = operandIn;

  // Logarithmic left shifter: one conditional power-of-two stage per bit.
  for (genvar i = 0; i < LEFT_STAGES; i++) begin : g_left
    localparam int SH = 2 ** i;
    assign leftStage[i+1] = leftAmt[i] ? (leftStage[i] << SH) : leftStage[i];
  end

  // Logarithmic right shifter with selectable fill; a stage as wide as the
  // operand replaces everything with the fill bit.
  for (genvar i = 0; i < SEL_W; i++) begin : g_right
    localparam int SH = 2 ** i;
    if (SH < DATA_W) begin : g_part
      assign rightStage[i+1] = rightMag[i]
        ? {{SH{fillBit}}, rightStage[i][DATA_W-1:SH]}
        : rightStage[i];
    end else begin : g_full
      assign rightStage[i+1] = rightMag[i] ? {DATA_W{fillBit}} : rightStage[i];
    end
  end

  assign shiftOut = goLeft ? leftStage[LEFT_STAGES] : rightStage[SEL_W];

  always_comb begin
    flagsNext.zero  = ~|shiftOut;
    flagsNext.neg   = shiftOut[DATA_W-1];
    flagsNext.carry = 1'b0;
    flagsNext.ovf0  = 1'b0;
    flagsNext.ovf1  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      resultOut <= '0;
      flagsOut  <= '0;
    end else if (strobes.load) begin
      resultOut <= shiftOut;
      flagsOut  <= flagsNext;
    end
  end

endmodule

// File: rtl/count_shift_unit.sv
module count_shift_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic              arithModeIn,
  output logic              outValid,
  output logic [DATA_W-1:0] resultOut,
  output logic              flagZero,
  output logic              flagNeg,
  output logic              flagCarry,
  output logic              flagOvf0,
  output logic              flagOvf1
);

  localparam int SEL_W = $clog2(DATA_W) + 1;

  ctrl_strobe_t strobes;
  flag_set_t    flags;
  fill_mode_e   fillMode;
  logic         unusedCountHigh;

  assign fillMode        = fill_mode_e'(arithModeIn);
  assign unusedCountHigh = ^countIn[CNT_W-1:SEL_W];

  shift_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  shift_datapath #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .operandIn (operandIn),
    .stepIn    (countIn[SEL_W-1:0]),
    .fillMode  (fillMode),
    .resultOut (resultOut),
    .flagsOut  (flags)
  );

  assign flagZero  = flags.zero;
  assign flagNeg   = flags.neg;
  assign flagCarry = flags.carry;
  assign flagOvf0  = flags.ovf0;
  assign flagOvf1  = flags.ovf1;

endmodule

// File: rtl/shift_checks.sv
module shift_checks #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [DATA_W-1:0] operandIn,
  input logic [CNT_W-1:0]  countIn,
  input logic              outValid,
  input logic [DATA_W-1:0] resultOut,
  input logic              flagZero,
  input logic              flagNeg,
  input logic              flagCarry,
  input logic              flagOvf0,
  input logic              flagOvf1
);

  localparam int SEL_W = $clog2(DATA_W) + 1;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R9

  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R9

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(resultOut) && $stable(flagZero) && $stable(flagNeg)); // R10

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (flagZero == (resultOut == '0))); // R6

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (flagNeg == resultOut[DATA_W-1])); // R7

  AST_NO_CARRY_OVF: assert property (@(posedge clk) disable iff (rst)
    !flagCarry && !flagOvf0 && !flagOvf1); // R8

  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (rst)
    (inValid && countIn[SEL_W-1:0] == '0) |=> resultOut == $past(operandIn)); // R5

endmodule

bind count_shift_unit shift_checks #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_checks (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .operandIn (operandIn),
  .countIn   (countIn),
  .outValid  (outValid),
  .resultOut (resultOut),
  .flagZero  (flagZero),
  .flagNeg   (flagNeg),
  .flagCarry (flagCarry),
  .flagOvf0  (flagOvf0),
  .flagOvf1  (flagOvf1)
);

// File: tb/tb_count_shift_unit.sv
`timescale 1ns/1ps
module tb_count_shift_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] operandIn = '0;
  logic [15:0] countIn = '0;
  logic        arithModeIn = 1'b0;
  logic        outValid;
  logic [31:0] resultOut;
  logic        flagZero, flagNeg, flagCarry, flagOvf0, flagOvf1;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;

  count_shift_unit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .operandIn(operandIn),
    .countIn(countIn), .arithModeIn(arithModeIn), .outValid(outValid),
    .resultOut(resultOut), .flagZero(flagZero), .flagNeg(flagNeg),
    .flagCarry(flagCarry), .flagOvf0(flagOvf0), .flagOvf1(flagOvf1)
  );

  function automatic logic [31:0] refShift(input logic [31:0] op,
                                           input logic [15:0] cnt,
                                           input logic arith);
    int amt;
    logic [63:0] ext;
    amt = int'(signed'(cnt[5:0]));
    if (amt >= 0) return op << amt;
    ext = {(arith ? {32{op[31]}} : 32'h0), op};
    ext = ext >> (-amt);
    return ext[31:0];
  endfunction

  function automatic string reqFor(input logic [15:0] cnt, input logic arith);
    int amt;
    amt = int'(signed'(cnt[5:0]));
    if (cnt[15:6] != 0 || cnt[5:0] == 6'd32) return "R1";
    if (amt == 0) return "R5";
    if (amt > 0) return "R2";
    return arith ? "R3" : "R4";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic runShift(input logic [31:0] op, input logic [15:0] cnt,
                          input logic arith);
    logic [31:0] exp;
    exp = refShift(op, cnt, arith);
    @(negedge clk);
    operandIn = op; countIn = cnt; arithModeIn = arith; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(reqFor(cnt, arith), "result", resultOut, exp);
    check("R9", "outValid pulse", {31'b0, outValid}, 32'd1);
    check("R6", "zero flag", {31'b0, flagZero}, {31'b0, exp == 32'h0});
    check("R7", "neg flag", {31'b0, flagNeg}, {31'b0, exp[31]});
    check("R8", "carry/ovf", {29'b0, flagCarry, flagOvf0, flagOvf1}, 32'd0);
    // Inputs move with the strobe low: outputs must hold.
    operandIn = ~op; countIn = cnt + 16'd3; arithModeIn = ~arith;
    @(negedge clk);
    check("R9", "outValid low", {31'b0, outValid}, 32'd0);
    check("R10", "held result", resultOut, exp);
    check("R10", "held flags", {30'b0, flagZero, flagNeg},
          {30'b0, exp == 32'h0, exp[31]});
  endtask

  task automatic checkCleared(input string what);
    check("R11", what, {resultOut[31:0]}, 32'h0);
    check("R11", {what, " flags/valid"},
          {26'b0, outValid, flagZero, flagNeg, flagCarry, flagOvf0, flagOvf1}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkCleared("reset state");

    // Directed corner cases
    runShift(32'h8000_0001, 16'd1, 1'b1);        // R2 -> 0x00000002
    runShift(32'h8000_0001, 16'd31, 1'b1);       // R2 -> 0x80000000
    runShift(32'h8000_0001, 16'd31, 1'b0);       // R2
    runShift(32'h8000_0001, 16'hFFFF, 1'b1);     // R3 -1 -> 0xC0000000
    runShift(32'h8000_0001, 16'hFFE1, 1'b1);     // R3 -31 -> 0xFFFFFFFF
    runShift(32'h8000_0001, 16'hFFE0, 1'b1);     // R3 -32 all ones
    runShift(32'h8000_0001, 16'hFFFF, 1'b0);     // R4 -1 -> 0x40000000
    runShift(32'h8000_0001, 16'hFFE1, 1'b0);     // R4 -31 -> 0x00000001
    runShift(32'h8000_0001, 16'hFFE0, 1'b0);     // R4 -32 -> 0
    runShift(32'h8000_0001, 16'd32, 1'b1);       // R1 32 as -32
    runShift(32'h8000_0001, 16'd40, 1'b1);       // R1 40 as -24 -> 0xFFFFFF80
    runShift(32'h8000_0001, 16'd40, 1'b0);       // R1 -> 0x00000080
    runShift(32'h0000_0001, 16'd63, 1'b1);       // R1 63 as -1 -> 0
    runShift(32'h0000_0100, 16'd255, 1'b1);      // R1 255 as -1 -> 0x80
    runShift(32'h1234_5678, 16'h7FC4, 1'b0);     // R1 high bits ignored, +4
    runShift(32'h8000_0001, 16'd0, 1'b1);        // R5 pass-through
    runShift(32'h8000_0001, 16'hABC0, 1'b0);     // R5 low bits zero
    runShift(32'h0000_0000, 16'd1, 1'b0);        // R6 zero result

    // Mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkCleared("mid-run reset");

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] op;
      logic [15:0] cnt;
      op  = $urandom();
      cnt = 16'($urandom());
      if (n % 5 == 0) op = {op[31], 31'h0} | (op & 32'h0000_000F);
      runShift(op, cnt, 1'($urandom()));
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule